// File: doc/BRIEF.md
# Chip-Select Bank Address Decoder

This block steers each bus request to one of a set of programmable memory banks. Every bank holds two 32-bit configuration words. The base word gives the bank's address, its data port width, the kind of memory controller that serves it, an ECC mode, a write-protect flag and an enable flag. The option word gives an address mask. Software loads both words through a simple write port.

For each request the decoder compares the upper address bits with every bank's base under that bank's mask. It picks the winning bank, drives a one-hot chip select, and reports the bank's attributes so that the matching memory controller can take over. A write that lands on a protected bank is refused: no chip select is raised, and an error pulse is given instead.

All outputs are registered. They describe the request presented at the previous rising clock edge.

Top module: `bank_decoder`

## Requirements
- R1: A bank matches when `(addr[31:15] & opt[31:15]) == (base[31:15] & opt[31:15])`. Address bits 14:0 never take part in the comparison.
- R2: A bank whose base bit 0 (enable) is clear never matches.
- R3: Base bits 12:11 give the port width code: 01 is 8-bit, 10 is 16-bit and 11 is 32-bit. The code of the winning bank is driven on `port_w_o`. A bank with code 00 never matches.
- R4: Base bits 7:5 give the controller type: 000 general-purpose, 001 NAND flash, 011 SDRAM, and 100/101/110 programmable machines A/B/C. The code of the winning bank is driven on `mach_o`. Codes 010 and 111 make the bank never match.
- R5: When several banks match, the lowest-numbered bank wins.
- R6: Base bit 8 is write protect. A write that wins a protected bank drives `cs_o` to zero, sets `hit_o`, and sets `wp_err_o` for exactly that one result cycle. A read of a protected bank is served normally.
- R7: Base bits 10:9 (ECC mode: 00 off, 01 check, 10 check and generate) of the winning bank are passed unchanged to `ecc_o`.
- R8: Results appear one clock after the request. A cycle without a request, or a request that matches no bank, gives all outputs zero.
- R9: After reset every bank word is zero, so no bank is enabled, and every output is zero.
- R10: `cs_o` has at most one bit set, and a set bit is always accompanied by `hit_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_opt | input | 1 | 0 selects the base word, 1 selects the option word |
| cfg_bank | input | 3 | Bank index for the write |
| cfg_data | input | 32 | Word to store |
| req_valid | input | 1 | Request present |
| req_addr | input | 32 | Request address |
| req_write | input | 1 | 1 for a write, 0 for a read |
| cs_o | output | 8 | One-hot chip select |
| hit_o | output | 1 | A bank matched |
| port_w_o | output | 2 | Port width code of the winner |
| mach_o | output | 3 | Controller type of the winner |
| ecc_o | output | 2 | ECC mode of the winner |
| wp_err_o | output | 1 | Write-protect violation pulse |

## Verification
A corrupted bank word, or a wrong priority choice, shows up in the very next result cycle as the wrong chip-select bit or the wrong attribute fields. The bench therefore compares every cycle's outputs with a reference computed from shadow copies of the bank words. A stuck or stretched error pulse shows up on the idle cycle that follows a refused write. A qualifier decoded wrongly shows up as a false hit on a bank that is disabled, has a zero width or has a reserved type.

// File: rtl/bank_decoder.sv
module bank_decoder #(
  parameter int NB  = 8,
  parameter int LSB = 15
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cfg_we,
  input  logic                  cfg_opt,
  input  logic [$clog2(NB)-1:0] cfg_bank,
  input  logic [31:0]           cfg_data,
  input  logic                  req_valid,
  input  logic [31:0]           req_addr,
  input  logic                  req_write,
  output logic [NB-1:0]         cs_o,
  output logic                  hit_o,
  output logic [1:0]            port_w_o,
  output logic [2:0]            mach_o,
  output logic [1:0]            ecc_o,
  output logic                  wp_err_o
);
  localparam int IW = $clog2(NB);

  logic [31:0]   base_q [NB];
  logic [31:0]   opt_q  [NB];
  logic [NB-1:0] match;
  logic [IW-1:0] win;
  logic          found;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NB; i++) begin
        base_q[i] <= '0;
        opt_q[i]  <= '0;
      end
    end else if (cfg_we) begin
      if (cfg_opt) opt_q[cfg_bank]  <= cfg_data;
      else         base_q[cfg_bank] <= cfg_data;
    end
  end

  for (genvar g = 0; g < NB; g++) begin : g_bank
    logic [31-LSB:0] msk;
    logic            type_ok;
    assign msk     = opt_q[g][31:LSB];
    assign type_ok = (base_q[g][7:5] != 3'b010) && (base_q[g][7:5] != 3'b111);
    assign match[g] = base_q[g][0] && (base_q[g][12:11] != 2'b00) && type_ok &&
                      ((req_addr[31:LSB] & msk) == (base_q[g][31:LSB] & msk));
  end

  always_comb begin
    win   = '0;
    found = 1'b0;
    for (int i = NB - 1; i >= 0; i--) begin
      if (match[i]) begin
        win   = IW'(i);
        found = 1'b1;
      end
    end
  end

  logic [31:0]   wb;
  logic          take;
  logic          deny;
  logic [NB-1:0] oh;

  assign wb   = base_q[win];
  assign take = req_valid && found;
  assign deny = take && req_write && wb[8];
  assign oh   = {{(NB-1){1'b0}}, 1'b1} << win;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cs_o     <= '0;
      hit_o    <= 1'b0;
      port_w_o <= '0;
      mach_o   <= '0;
      ecc_o    <= '0;
      wp_err_o <= 1'b0;
    end else begin
      cs_o     <= (take && !deny) ? oh : '0;
      hit_o    <= take;
      port_w_o <= take ? wb[12:11] : 2'b00;
      mach_o   <= take ? wb[7:5]   : 3'b000;
      ecc_o    <= take ? wb[10:9]  : 2'b00;
      wp_err_o <= deny;
    end
  end

  a_r10_onehot: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(cs_o));
  a_r10_cs_hit: assert property (@(posedge clk) disable iff (!rst_n) (cs_o != '0) |-> hit_o);
  a_r6_err_nocs: assert property (@(posedge clk) disable iff (!rst_n) wp_err_o |-> (cs_o == '0 && hit_o));
  a_r6_err_write: assert property (@(posedge clk) disable iff (!rst_n) wp_err_o |-> $past(req_write && req_valid));
  a_r8_idle: assert property (@(posedge clk) disable iff (!rst_n) !$past(req_valid) |-> (!hit_o && !wp_err_o));
endmodule

// File: tb/sim_bank_decoder.sv
module sim_bank_decoder;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        cfg_we = 0, cfg_opt = 0;
  logic [2:0]  cfg_bank = 0;
  logic [31:0] cfg_data = 0;
  logic        req_valid = 0, req_write = 0;
  logic [31:0] req_addr = 0;
  logic [7:0]  cs_o;
  logic        hit_o, wp_err_o;
  logic [1:0]  port_w_o, ecc_o;
  logic [2:0]  mach_o;

  always #10 clk = ~clk;

  bank_decoder u0 (.*);

  typedef struct {
    logic [7:0] cs; logic hit; logic [1:0] pw; logic [2:0] ms; logic [1:0] ecc; logic wp;
    string tag;
  } item_t;

  item_t q[$];
  int n_cmp = 0, n_bad = 0;
  logic [31:0] sb [8];
  logic [31:0] so [8];

  function automatic item_t model(logic v, logic [31:0] a, logic w, string tag);
    item_t r;
    r = '{cs: 0, hit: 0, pw: 0, ms: 0, ecc: 0, wp: 0, tag: tag};
    if (v) begin
      for (int i = 0; i < 8; i++) begin
        logic [2:0] t;
        t = sb[i][7:5];
        if (sb[i][0] && sb[i][12:11] != 0 && t != 3'b010 && t != 3'b111 &&
            ((a[31:15] & so[i][31:15]) == (sb[i][31:15] & so[i][31:15]))) begin
          r.hit = 1; r.pw = sb[i][12:11]; r.ms = t; r.ecc = sb[i][10:9];
          if (w && sb[i][8]) r.wp = 1; else r.cs = 8'(1 << i);
          break;
        end
      end
    end
    return r;
  endfunction

  function automatic logic [31:0] mkb(logic [31:0] ba, logic [1:0] ps, logic [1:0] ecc,
                                      logic wp, logic [2:0] ms, logic v);
    return {ba[31:15], 2'b00, ps, ecc, wp, ms, 4'b0000, v};
  endfunction

  task automatic cfg(int b, logic o, logic [31:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_opt = o; cfg_bank = 3'(b); cfg_data = d; req_valid = 0;
    if (o) so[b] = d; else sb[b] = d;
    q.push_back(model(0, 0, 0, "R8"));
    @(negedge clk);
    cfg_we = 0;
    q.push_back(model(0, 0, 0, "R8"));
  endtask

  task automatic req(logic [31:0] a, logic w, string tag);
    @(negedge clk);
    req_valid = 1; req_addr = a; req_write = w;
    q.push_back(model(1, a, w, tag));
  endtask

  task automatic idle(string tag);
    @(negedge clk);
    req_valid = 0; req_write = 0;
    q.push_back(model(0, 0, 0, tag));
  endtask

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    #2;
    if (rst_n && q.size() > 0) begin
      item_t e;
      e = q.pop_front();
      chk(e.tag, {cs_o, hit_o, port_w_o, mach_o, ecc_o, wp_err_o},
          {e.cs, e.hit, e.pw, e.ms, e.ecc, e.wp});
    end
  end

  initial begin
    for (int i = 0; i < 8; i++) begin sb[i] = 0; so[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R9 reset outputs", {cs_o, hit_o, port_w_o, mach_o, ecc_o, wp_err_o}, 0);
    req(32'h1008_0000, 0, "R9 no bank enabled");
    cfg(0, 0, mkb(32'h1000_0000, 2'b11, 2'b01, 0, 3'b000, 1));
    cfg(0, 1, 32'hFFF0_0000);
    req(32'h1008_0000, 0, "R1 R7 bank0 hit");
    req(32'h1008_7FFF, 1, "R1 low bits ignored");
    req(32'h2000_0000, 0, "R1 miss");
    idle("R8 idle");
    cfg(1, 0, mkb(32'h1000_0000, 2'b01, 2'b10, 0, 3'b011, 1));
    cfg(1, 1, 32'hF000_0000);
    req(32'h1008_0000, 0, "R5 lowest wins");
    req(32'h1F00_0000, 0, "R1 R4 bank1 broad mask");
    cfg(2, 1, 32'hFFFF_8000);
    cfg(2, 0, mkb(32'h4000_0000, 2'b10, 2'b00, 0, 3'b101, 0));
    req(32'h4000_0000, 0, "R2 disabled bank");
    cfg(2, 0, mkb(32'h4000_0000, 2'b00, 2'b00, 0, 3'b101, 1));
    req(32'h4000_0000, 0, "R3 width 00 no match");
    cfg(2, 0, mkb(32'h4000_0000, 2'b10, 2'b00, 0, 3'b010, 1));
    req(32'h4000_0000, 0, "R4 type 010 no match");
    cfg(2, 0, mkb(32'h4000_0000, 2'b10, 2'b00, 0, 3'b111, 1));
    req(32'h4000_0000, 0, "R4 type 111 no match");
    cfg(2, 0, mkb(32'h4000_0000, 2'b10, 2'b10, 0, 3'b101, 1));
    req(32'h4000_0000, 1, "R3 R4 bank2 16-bit machine B");
    cfg(3, 1, 32'hFFFF_8000);
    cfg(3, 0, mkb(32'h6000_0000, 2'b01, 2'b00, 1, 3'b001, 1));
    req(32'h6000_0000, 0, "R6 protected read served");
    req(32'h6000_0000, 1, "R6 protected write refused");
    idle("R6 pulse ends");
    req(32'h6000_0000, 1, "R6 refused again");
    req(32'h1000_0000, 1, "R6 unprotected write");
    cfg(4, 1, 32'h0000_8000);
    cfg(4, 0, mkb(32'h8000_8000, 2'b11, 2'b01, 0, 3'b100, 1));
    req(32'h5234_8000, 0, "R1 single mask bit");
    req(32'h5234_0000, 0, "R1 single mask bit miss");
    req(32'h0000_0000, 0, "R10 onehot");
    idle("R8 final idle");
    repeat (3) @(negedge clk);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule